// File: doc/BRIEF.md
# Crossing-Grouped Hit Packer

This block turns a stream of pixel hits into 32-bit link words. Every hit carries a chip id, a crossing number, a pixel address and a 3-bit ADC value. Hits that share both the crossing number and the chip id are collected into one packet. A packet starts with a 16-bit header, continues with 16-bit data halves and ends on a 32-bit boundary.

A packet stays open while hits keep matching it. It is closed when a hit arrives with a different crossing or chip, or when no hit has been accepted for a fixed idle span. Single-word control packets arrive on a second input and are placed only between pixel packets. All three interfaces use a valid/ready handshake. Each output word stays in one output register until the consumer takes it.

Top module: `hit_packer`

## Requirements
- R1: A pixel header half is {2'b10, 1'b0, chip[4:0], crossing[7:0]}: bits 15-14 are 10, bit 13 is 0, bits 12-8 hold the chip id and bits 7-0 hold the crossing number.
- R2: A pixel data half is {1'b0, address[11:0], adc[2:0]}: bit 15 is 0, bits 14-3 hold the address and bits 2-0 hold the ADC value.
- R3: Halves fill words high half first. The header is bits 31-16 of a packet's first word, and the first hit's data half is bits 15-0 of that word.
- R4: A hit whose crossing and chip match the open packet extends it. A hit whose crossing differs closes the open packet and starts a new one with its own header.
- R5: A hit with the same crossing but a different chip id also closes the open packet and opens a new one.
- R6: When a closing packet has an odd number of halves, its last word carries the final data half in bits 31-16 and zero in bits 15-0. A packet with an even number of halves closes with no extra word.
- R7: An accepted control request leaves as exactly one word, {2'b11, payload[29:0]}.
- R8: A control request is not accepted while a pixel packet is open. It leaves after the open packet's last word.
- R9: Take edge 0 as the edge that accepts a packet's last hit, with out_ready held high. If a data half is still waiting, out_valid stays low through edge 16 and the pad word is valid just after edge 17.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_word does not change on the next edge.
- R11: After reset, out_valid is low and both hit_ready and ctl_ready are high.
- R12: The first word of a packet is valid on out_word right after the edge that accepts the packet's first hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | Hit offered |
| hit_ready | output | 1 | Hit taken on this edge |
| hit_chip | input | 5 | Chip id of the hit |
| hit_xing | input | 8 | Crossing number of the hit |
| hit_addr | input | 12 | Pixel address |
| hit_adc | input | 3 | ADC value |
| ctl_valid | input | 1 | Control request offered |
| ctl_ready | output | 1 | Control request taken on this edge |
| ctl_payload | input | 30 | Control packet body |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the output word |
| out_word | output | 32 | Link word |

## Verification
A packet's first word and a control word each sit in the output register and are due right after the edge that accepts their input. The bench checks out_word at the negative edge that follows the accepting edge. A pad word forced by the idle timer is due 17 edges after the last accepted hit. The bench counts negative edges from that hit's acceptance, checks that out_valid is still low after the 16th edge and checks the word after the 17th. Packet-order checks under backpressure record every word at the negative edge before the edge that transfers it, and compare the sequence with the list built from R1 to R8.

// File: rtl/hit_packer_pkg.sv
package hit_packer_pkg;
    localparam int CHIP_W = 5;
    localparam int XING_W = 8;
    localparam int ADDR_W = 12;
    localparam int ADC_W  = 3;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int CTL_W  = WORD_W - 2;

    typedef struct packed {
        logic [CHIP_W-1:0] chip;
        logic [XING_W-1:0] xing;
        logic [ADDR_W-1:0] addr;
        logic [ADC_W-1:0]  adc;
    } hit_t;

    typedef struct packed {
        logic              open;
        logic              has_hi;
        logic [HALF_W-1:0] hi;
        logic [CHIP_W-1:0] chip;
        logic [XING_W-1:0] xing;
        logic              out_valid;
        logic [WORD_W-1:0] out_word;
    } pk_state_t;
endpackage

// File: rtl/hit_packer_format.sv
module hit_packer_format
    import hit_packer_pkg::*;
(
    input  hit_t              hit,
    output logic [HALF_W-1:0] hdr_half,
    output logic [HALF_W-1:0] dat_half
);
    // header: tag 10, spare zero, chip id, crossing
    assign hdr_half = {2'b10, 1'b0, hit.chip, hit.xing};
    // data: marker zero, address, adc
    assign dat_half = {1'b0, hit.addr, hit.adc};
endmodule

// File: rtl/hit_packer_idle_timer.sv
module hit_packer_idle_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q >= CW'(LIMIT));

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (run && !expired)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9
    cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT));
endmodule

// File: rtl/hit_packer.sv
module hit_packer
    import hit_packer_pkg::*;
#(
    parameter int IDLE_LIMIT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hit_valid,
    output logic        hit_ready,
    input  logic [4:0]  hit_chip,
    input  logic [7:0]  hit_xing,
    input  logic [11:0] hit_addr,
    input  logic [2:0]  hit_adc,
    input  logic        ctl_valid,
    output logic        ctl_ready,
    input  logic [29:0] ctl_payload,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_word
);
    pk_state_t s_d, s_q;
    hit_t      hit_in;
    logic [HALF_W-1:0] hdr_half, dat_half;
    logic slot_free, match, close_now, hit_acc, ctl_acc, expired;

    assign hit_in = '{chip: hit_chip, xing: hit_xing, addr: hit_addr, adc: hit_adc};

    hit_packer_format fmt_i (
        .hit      (hit_in),
        .hdr_half (hdr_half),
        .dat_half (dat_half)
    );

    hit_packer_idle_timer #(.LIMIT(IDLE_LIMIT)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (s_q.open),
        .clear   (hit_acc || !s_q.open),
        .expired (expired)
    );

    assign slot_free = !s_q.out_valid || out_ready;
    assign match     = (hit_chip == s_q.chip) && (hit_xing == s_q.xing);
    assign close_now = slot_free && s_q.open && (expired || (hit_valid && !match));
    assign hit_ready = slot_free && (s_q.open ? !(expired || !match) : !ctl_valid);
    assign ctl_ready = slot_free && !s_q.open;
    assign hit_acc   = hit_valid && hit_ready;
    assign ctl_acc   = ctl_valid && ctl_ready;

    always_comb begin
        s_d = s_q;
        if (slot_free)
            s_d.out_valid = 1'b0;
        if (close_now) begin
            s_d.open = 1'b0;
            if (s_q.has_hi) begin
                s_d.has_hi    = 1'b0;
                s_d.out_valid = 1'b1;
                s_d.out_word  = {s_q.hi, {HALF_W{1'b0}}};
            end
        end else if (ctl_acc) begin
            s_d.out_valid = 1'b1;
            s_d.out_word  = {2'b11, ctl_payload};
        end else if (hit_acc) begin
            if (!s_q.open) begin
                s_d.open      = 1'b1;
                s_d.chip      = hit_chip;
                s_d.xing      = hit_xing;
                s_d.has_hi    = 1'b0;
                s_d.out_valid = 1'b1;
                s_d.out_word  = {hdr_half, dat_half};
            end else if (s_q.has_hi) begin
                s_d.has_hi    = 1'b0;
                s_d.out_valid = 1'b1;
                s_d.out_word  = {s_q.hi, dat_half};
            end else begin
                s_d.has_hi = 1'b1;
                s_d.hi     = dat_half;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.out_valid;
    assign out_word  = s_q.out_word;

    // R10
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    // R7
    ctl_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_ready) |=>
            (out_valid && out_word[31:30] == 2'b11 && out_word[29:0] == $past(ctl_payload)));

    // R8
    ctl_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_ready) |-> !s_q.has_hi);

    // R6
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (close_now && s_q.has_hi) |=> (out_valid && out_word[15:0] == 16'h0000));

    // R12
    first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_acc && !s_q.open) |=> (out_valid && out_word[31:30] == 2'b10));
endmodule

// File: tb/hit_packer_tb.sv
module hit_packer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hit_valid = 1'b0;
    logic        hit_ready;
    logic [4:0]  hit_chip = '0;
    logic [7:0]  hit_xing = '0;
    logic [11:0] hit_addr = '0;
    logic [2:0]  hit_adc = '0;
    logic        ctl_valid = 1'b0;
    logic        ctl_ready;
    logic [29:0] ctl_payload = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_word;

    int checks = 0;
    int failures = 0;
    bit bp_mode = 1'b0;
    int cyc = 0;
    logic [31:0] got[$];
    logic [31:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hit_packer dut_i (
        .clk(clk), .rst_n(rst_n),
        .hit_valid(hit_valid), .hit_ready(hit_ready),
        .hit_chip(hit_chip), .hit_xing(hit_xing), .hit_addr(hit_addr), .hit_adc(hit_adc),
        .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_payload(ctl_payload),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
    );

    // ready is set first so the recorded transfer matches the coming edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        out_ready = bp_mode ? ((cyc % 3) != 0) : 1'b1;
        if (rst_n && out_valid && out_ready) got.push_back(out_word);
    end

    function automatic logic [15:0] hdr(input logic [4:0] c, input logic [7:0] x);
        return {2'b10, 1'b0, c, x};
    endfunction
    function automatic logic [15:0] dat(input logic [11:0] a, input logic [2:0] v);
        return {1'b0, a, v};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic send_hit(input logic [4:0] c, input logic [7:0] x, input logic [11:0] a, input logic [2:0] v);
        hit_chip = c; hit_xing = x; hit_addr = a; hit_adc = v; hit_valid = 1'b1;
        #1;
        while (!hit_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        hit_valid = 1'b0;
    endtask

    task automatic send_ctl(input logic [29:0] p);
        ctl_payload = p; ctl_valid = 1'b1;
        #1;
        while (!ctl_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        ctl_valid = 1'b0;
    endtask

    task automatic compare(input string req);
        check(got.size() == exp_q.size(), req, got.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got.size(); i++)
            check(got[i] === exp_q[i], req, got[i], exp_q[i]);
        got.delete();
        exp_q.delete();
    endtask

    task automatic t_reset();
        // R11
        check(out_valid == 1'b0, "R11", out_valid, 0);
        check(hit_ready == 1'b1, "R11", hit_ready, 1);
        check(ctl_ready == 1'b1, "R11", ctl_ready, 1);
    endtask

    task automatic t_single();
        // R12 R1 R2 R3: first word due right after the accepting edge
        send_hit(5'd3, 8'h21, 12'hABC, 3'd5);
        check(out_valid == 1'b1, "R12", out_valid, 1);
        check(out_word == {hdr(5'd3, 8'h21), dat(12'hABC, 3'd5)}, "R1 R2 R3", out_word,
              {hdr(5'd3, 8'h21), dat(12'hABC, 3'd5)});
        exp_q.push_back({hdr(5'd3, 8'h21), dat(12'hABC, 3'd5)});
        repeat (25) @(negedge clk);
        compare("R6 even packet");
    endtask

    task automatic t_timeout();
        // R9 R6
        send_hit(5'd1, 8'h40, 12'h111, 3'd1);
        send_hit(5'd1, 8'h40, 12'h222, 3'd2);
        repeat (16) @(negedge clk);
        check(out_valid == 1'b0, "R9", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R9", out_valid, 1);
        check(out_word == {dat(12'h222, 3'd2), 16'h0000}, "R9 R6", out_word,
              {dat(12'h222, 3'd2), 16'h0000});
        exp_q.push_back({hdr(5'd1, 8'h40), dat(12'h111, 3'd1)});
        exp_q.push_back({dat(12'h222, 3'd2), 16'h0000});
        repeat (3) @(negedge clk);
        compare("R9");
    endtask

    task automatic t_xing();
        // R4
        send_hit(5'd2, 8'h10, 12'h00A, 3'd3);
        send_hit(5'd2, 8'h10, 12'h00B, 3'd4);
        send_hit(5'd2, 8'h11, 12'h00C, 3'd6);
        repeat (25) @(negedge clk);
        exp_q.push_back({hdr(5'd2, 8'h10), dat(12'h00A, 3'd3)});
        exp_q.push_back({dat(12'h00B, 3'd4), 16'h0000});
        exp_q.push_back({hdr(5'd2, 8'h11), dat(12'h00C, 3'd6)});
        compare("R4");
    endtask

    task automatic t_chip();
        // R5
        send_hit(5'd4, 8'h50, 12'h301, 3'd0);
        send_hit(5'd5, 8'h50, 12'h302, 3'd7);
        send_hit(5'd5, 8'h50, 12'h303, 3'd1);
        repeat (25) @(negedge clk);
        exp_q.push_back({hdr(5'd4, 8'h50), dat(12'h301, 3'd0)});
        exp_q.push_back({hdr(5'd5, 8'h50), dat(12'h302, 3'd7)});
        exp_q.push_back({dat(12'h303, 3'd1), 16'h0000});
        compare("R5");
    endtask

    task automatic t_ctl();
        // R8: request held off while a packet is open
        send_hit(5'd6, 8'h60, 12'h444, 3'd2);
        send_hit(5'd6, 8'h60, 12'h555, 3'd3);
        ctl_payload = 30'h1234567; ctl_valid = 1'b1;
        #1;
        check(ctl_ready == 1'b0, "R8", ctl_ready, 0);
        send_ctl(30'h1234567);
        // R7: idle control request
        send_ctl(30'h2ABCDEF);
        repeat (5) @(negedge clk);
        exp_q.push_back({hdr(5'd6, 8'h60), dat(12'h444, 3'd2)});
        exp_q.push_back({dat(12'h555, 3'd3), 16'h0000});
        exp_q.push_back({2'b11, 30'h1234567});
        exp_q.push_back({2'b11, 30'h2ABCDEF});
        compare("R7 R8");
    endtask

    task automatic t_backpressure();
        // R10 R3 R4 under a stalling consumer
        bp_mode = 1'b1;
        for (int i = 0; i < 5; i++)
            send_hit(5'd9, 8'h77, 12'(i + 16), 3'(i));
        send_hit(5'd9, 8'h78, 12'hFFF, 3'd7);
        send_ctl(30'h0000F0F);
        repeat (30) @(negedge clk);
        exp_q.push_back({hdr(5'd9, 8'h77), dat(12'd16, 3'd0)});
        exp_q.push_back({dat(12'd17, 3'd1), dat(12'd18, 3'd2)});
        exp_q.push_back({dat(12'd19, 3'd3), dat(12'd20, 3'd4)});
        exp_q.push_back({hdr(5'd9, 8'h78), dat(12'hFFF, 3'd7)});
        exp_q.push_back({2'b11, 30'h0000F0F});
        compare("R10");
        bp_mode = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_timeout();
        t_xing();
        t_chip();
        t_ctl();
        t_backpressure();
        finish_run();
    end
endmodule